// File: doc/BRIEF.md
# SD Card Clock Divider with Identification and Data Modes

This block derives the SD card bit clock from the core clock. A stored divider value N sets the SD clock period to N+2 core cycles. While the card is being identified, all of N is used, so very slow clocks are possible. Once the card is in data mode, only the low bits of N are used, so the same stored value gives a fast clock without being rewritten. A slow-card control bit cancels that switch and keeps the full-width divisor in both modes.

The block produces a registered SD clock and a clock-enable pulse that is one core cycle wide. Logic that runs on the SD bit rate uses the pulse. A new divider value, a mode change or a change of the slow-card bit is picked up only at the end of the SD clock period in progress. The period running when the change arrives therefore completes at its old length.

Top module: `sdclk_div`

## Requirements
- R1: On reset the stored divider value is 507. The first SD clock period after reset release is 509 core cycles long in identification mode, and its enable pulse is seen in the first core cycle after release.
- R2: In identification mode (`data_mode` = 0) the SD clock period equals N+2 core cycles, where N is the full 11-bit stored value.
- R3: In data mode (`data_mode` = 1, `slow_card` = 0) only bits [2:0] of N are used, so the period is N[2:0]+2 (2 to 9 cycles).
- R4: With `slow_card` = 1 the full 11-bit N sets the period in data mode as well.
- R5: N = 0x7FF gives the longest period: 2049 cycles with the full divisor and 9 cycles in data mode. The clock never stops.
- R6: In every period `sd_clk` is high for floor(P/2) core cycles and low for the remaining cycles. The high phase comes first.
- R7: `sd_clk_en` is high for exactly one core cycle per period, in the same cycle that `sd_clk` goes from 0 to 1.
- R8: A change to N, `data_mode` or `slow_card` made during a period does not alter that period's length. The new value applies from the next period.
- R9: While `rst` is high, `sd_clk` and `sd_clk_en` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| div_wr | input | 1 | Write strobe for the divider value |
| div_wdata | input | 11 | New divider value N (period N+2) |
| data_mode | input | 1 | 0 = identification mode, 1 = data mode |
| slow_card | input | 1 | 1 = use the full divisor in data mode too |
| sd_clk | output | 1 | Registered SD clock |
| sd_clk_en | output | 1 | One-cycle pulse at each rising edge of sd_clk |

## Verification
The bench drives several divider values and measures the length and high time of each SD period.

- N = 0 (the shortest period), odd periods such as 5 and 9, and an even period of 8 show whether the high time is floored correctly.
- The value 0x3F3 is used in both modes. It gives 5 in data mode and 1013 in identification mode, which shows whether the upper bits are masked only when they should be.
- Toggling `slow_card` with N = 0x7FF in data mode tells the forced full divisor (2049) apart from the masked one (9).
- Every setting change is made during a running period, whose expected length stays the old one. This exposes any design that reloads before its terminal count.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

    localparam int SDCLK_DIV_W     = 11;
    localparam int SDCLK_DATA_BITS = 3;
    localparam int SDCLK_RST_DIV   = 507;

    typedef enum logic {
        DIV_IDENT = 1'b0,
        DIV_DATA  = 1'b1
    } div_kind_e;

    function automatic div_kind_e pick_kind(input logic dm, input logic slow);
        return (dm && !slow) ? DIV_DATA : DIV_IDENT;
    endfunction

endpackage

// File: rtl/sdclk_div_reg.sv
module sdclk_div_reg #(
    parameter int DIV_W   = 11,
    parameter int RST_DIV = 507
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [DIV_W-1:0] wdata,
    output logic [DIV_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= DIV_W'(RST_DIV);
        else if (wr) q <= wdata;
    end
endmodule

// File: rtl/sdclk_ratio_sel.sv
module sdclk_ratio_sel
    import sdclk_pkg::*;
#(
    parameter int DIV_W     = 11,
    parameter int DATA_BITS = 3,
    parameter int CNT_W     = DIV_W + 1
) (
    input  logic [DIV_W-1:0] div_n,
    input  div_kind_e        kind,
    output logic [CNT_W-1:0] period
);
    logic [DIV_W-1:0] data_n;
    logic [DIV_W-1:0] used_n;

    generate
        if (DATA_BITS < DIV_W) begin : g_mask
            assign data_n = {{(DIV_W-DATA_BITS){1'b0}}, div_n[DATA_BITS-1:0]};
        end else begin : g_full
            assign data_n = div_n;
        end
    endgenerate

    always_comb begin
        used_n = (kind == DIV_DATA) ? data_n : div_n;
        period = CNT_W'(used_n) + CNT_W'(2);
    end
endmodule

// File: rtl/sdclk_phase.sv
module sdclk_phase #(
    parameter int CNT_W   = 12,
    parameter int RST_PER = 509
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] next_per,
    output logic [CNT_W-1:0] cur_per,
    output logic             terminal,
    output logic             sd_clk,
    output logic             sd_clk_en
);
    logic [CNT_W-1:0] cnt_q, cnt_d, per_q, per_d;

    assign terminal = (cnt_q == per_q - CNT_W'(1));
    assign cur_per  = per_q;

    always_comb begin
        if (terminal) begin
            cnt_d = '0;
            per_d = next_per;
        end else begin
            cnt_d = cnt_q + CNT_W'(1);
            per_d = per_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= CNT_W'(RST_PER - 1);
            per_q     <= CNT_W'(RST_PER);
            sd_clk    <= 1'b0;
            sd_clk_en <= 1'b0;
        end else begin
            cnt_q     <= cnt_d;
            per_q     <= per_d;
            sd_clk    <= (cnt_d < (per_d >> 1));
            sd_clk_en <= (cnt_d == '0);
        end
    end

    // R2
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q < per_q) && (per_q >= CNT_W'(2)));

    // R8
    per_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !terminal |=> $stable(per_q));

    // R7
    en_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        sd_clk_en |-> (sd_clk && !$past(sd_clk)));

    // R7
    rise_has_en_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sd_clk) |-> sd_clk_en);
endmodule

// File: rtl/sdclk_div.sv
module sdclk_div
    import sdclk_pkg::*;
#(
    parameter int DIV_W     = SDCLK_DIV_W,
    parameter int DATA_BITS = SDCLK_DATA_BITS,
    parameter int RST_DIV   = SDCLK_RST_DIV
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_wdata,
    input  logic             data_mode,
    input  logic             slow_card,
    output logic             sd_clk,
    output logic             sd_clk_en
);
    localparam int CNT_W   = DIV_W + 1;
    localparam int RST_PER = RST_DIV + 2;
    localparam logic [CNT_W-1:0] DATA_MAX = CNT_W'((1 << DATA_BITS) + 1);

    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] next_per, cur_per;
    logic             term;
    div_kind_e        kind;

    assign kind = pick_kind(data_mode, slow_card);

    sdclk_div_reg #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) u_reg (
        .clk(clk), .rst(rst), .wr(div_wr), .wdata(div_wdata), .q(div_q)
    );

    sdclk_ratio_sel #(.DIV_W(DIV_W), .DATA_BITS(DATA_BITS), .CNT_W(CNT_W)) u_sel (
        .div_n(div_q), .kind(kind), .period(next_per)
    );

    sdclk_phase #(.CNT_W(CNT_W), .RST_PER(RST_PER)) u_phase (
        .clk(clk), .rst(rst), .next_per(next_per), .cur_per(cur_per),
        .terminal(term), .sd_clk(sd_clk), .sd_clk_en(sd_clk_en)
    );

    // R3
    data_period_max_chk: assert property (@(posedge clk) disable iff (rst)
        (term && kind == DIV_DATA) |=> (cur_per <= DATA_MAX));

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!sd_clk && !sd_clk_en));
endmodule

// File: tb/sdclk_div_tb.sv
module sdclk_div_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        div_wr = 1'b0;
    logic [10:0] div_wdata = '0;
    logic        data_mode = 1'b0;
    logic        slow_card = 1'b0;
    logic        sd_clk, sd_clk_en;

    int checks = 0;
    int fails  = 0;

    int    exp_per_q[$];
    string exp_tag_q[$];

    logic cur_dm = 1'b0, cur_sc = 1'b0;
    int   cur_n = 507;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdclk_div u_dut (
        .clk(clk), .rst(rst), .div_wr(div_wr), .div_wdata(div_wdata),
        .data_mode(data_mode), .slow_card(slow_card),
        .sd_clk(sd_clk), .sd_clk_en(sd_clk_en)
    );

    function automatic int exp_period(input logic dm, input logic sc, input int n);
        return (dm && !sc) ? (n % 8) + 2 : (n % 2048) + 2;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_pulse();
        do @(negedge clk); while (!sd_clk_en);
        #1;
    endtask

    task automatic push(input int per, input string tag);
        exp_per_q.push_back(per);
        exp_tag_q.push_back(tag);
    endtask

    // change settings inside a running period; that period keeps its old length (R8)
    task automatic apply(input logic dm, input logic sc, input logic wr,
                         input int nv, input int cnt, input string tag);
        wait_pulse();
        push(exp_period(cur_dm, cur_sc, cur_n), "R8");
        data_mode = dm;
        slow_card = sc;
        div_wr    = wr;
        div_wdata = 11'(nv);
        cur_dm = dm;
        cur_sc = sc;
        if (wr) cur_n = nv;
        @(negedge clk);
        div_wr = 1'b0;
        for (int i = 0; i < cnt; i++) begin
            wait_pulse();
            push(exp_period(cur_dm, cur_sc, cur_n), tag);
        end
    endtask

    // monitor: measures each period between enable pulses
    int   cyc = 0, hi = 0;
    bit   open = 0;
    logic prev_clk = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (sd_clk_en) begin
                // R7
                check(sd_clk && !prev_clk, "R7 pulse on rising edge", int'(prev_clk), 0);
                if (open && exp_per_q.size() > 0) begin
                    int    ep;
                    string et;
                    ep = exp_per_q.pop_front();
                    et = exp_tag_q.pop_front();
                    check(cyc == ep, {et, " period"}, cyc, ep);
                    // R6
                    check(hi == ep / 2, {et, " R6 high time"}, hi, ep / 2);
                end
                open = 1;
                cyc = 1;
                hi  = 1;
            end else begin
                cyc++;
                hi += int'(sd_clk);
            end
        end
        prev_clk = sd_clk;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R9
        check(!sd_clk && !sd_clk_en, "R9 outputs low in reset",
              int'({sd_clk, sd_clk_en}), 0);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(sd_clk_en && sd_clk, "R1 first pulse after release", int'(sd_clk_en), 1);
        #1;
        push(509, "R1");
        wait_pulse();
        push(509, "R1");

        apply(1'b0, 1'b0, 1'b1, 0,     4, "R2");
        apply(1'b0, 1'b0, 1'b1, 3,     3, "R2");
        apply(1'b0, 1'b0, 1'b1, 6,     2, "R2");
        apply(1'b1, 1'b0, 1'b1, 'h3F3, 3, "R3");
        apply(1'b0, 1'b0, 1'b0, 'h3F3, 1, "R2");
        apply(1'b1, 1'b0, 1'b1, 'h7FF, 2, "R5");
        apply(1'b1, 1'b1, 1'b0, 'h7FF, 2, "R4");
        apply(1'b1, 1'b0, 1'b0, 'h7FF, 2, "R3");
        apply(1'b0, 1'b0, 1'b0, 'h7FF, 1, "R5");
        apply(1'b0, 1'b0, 1'b1, 10,    2, "R2");
        wait_pulse();
        // R8
        check(exp_per_q.size() == 0, "R8 all periods observed", exp_per_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule